// File: doc/BRIEF.md
# Endpoint Target Read/Write Responder

This block sits behind an endpoint's transaction engine and serves memory reads and memory writes that the host directs at the card. The engine raises a read request or a write request. The responder answers both with a single accept pulse, which it holds back for a fixed number of pending cycles. Data starts to move in the same cycle as the accept: a write strobe carries write data and per-byte enables, and a read strobe asks for one word that the responder returns exactly one cycle later. A remaining-byte count arrives with every beat and tells the responder when the burst is over.

A seven-bit one-hot hit vector names the targeted window: three memory windows, three spare windows and the expansion ROM window. The first three windows are decoded as 32 KB, 4 KB and 32 KB spans. Each of them is backed by its own word store, whose depth is a parameter. The local address of a burst is captured once, at the accept. After that the responder steps one word per strobe on its own, so the engine's address lines are not used again until the next accept. The spare and ROM windows accept traffic but hold no storage.

Top module: `tgt_resp`

## Requirements
- R1: After reset, `accept` is low and `rd_data` is zero.
- R2: A request that stays pending in the idle state gets `accept` in the cycle that is exactly ACC_WAIT cycles after the first cycle it was seen. With ACC_WAIT of 0, that is the same cycle. The wait counter restarts after every accept.
- R3: When read and write requests are pending together, the read is accepted first. The write stays pending and is accepted ACC_WAIT cycles after the first idle cycle that follows the read.
- R4: A strobe in the accept cycle transfers the word selected by `laddr` in that cycle. Strobes are only honoured in the accept cycle and during an open burst, and only for the accepted direction.
- R5: The word read by a read strobe in cycle t appears on `rd_data` in cycle t+1. It then holds until the next read strobe.
- R6: In a write, `byte_en` bit i controls `wr_data` bits 8i+7..8i. Reads ignore `byte_en`.
- R7: The word index is `laddr` divided by DATA_W/8. The low byte-offset bits are dropped. Each honoured strobe advances the index by one word.
- R8: A strobe whose `rem_bytes` is at most DATA_W/8 is the last beat of the burst. After it, `accept` stays low until a new request arrives.
- R9: Hit bit 0 selects store 0, bit 1 selects store 1 and bit 2 selects store 2. The three stores are independent.
- R10: Hit bits 3 to 6 (three spare windows and the ROM window) are accepted. Writes to them change no store, and reads from them return all ones.
- R11: Store k holds Rk_WORDS words. A word index aliases modulo that depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request pending from the engine |
| wr_req | input | 1 | Write request pending from the engine |
| accept | output | 1 | Accepts the pending request; the transfer starts in this cycle |
| rd_stb | input | 1 | Read strobe: one word requested |
| wr_stb | input | 1 | Write strobe: `wr_data` is valid this cycle |
| bar_hit | input | 7 | One-hot window select: bits 0-2 stores, 3-5 spare, 6 ROM |
| laddr | input | ADDR_W | Byte address local to the window, sampled at accept |
| byte_en | input | DATA_W/8 | Per-byte write enables |
| wr_data | input | DATA_W | Write data |
| rem_bytes | input | 12 | Bytes left in the burst, counting the current beat |
| rd_data | output | DATA_W | Read data, one cycle after the read strobe |

## Verification
The bench sweeps every word of each store in bursts and reads everything back. This exposes a responder that re-reads `laddr` after the accept, or that drops the first beat in the accept cycle; either would leave holes or shifted words. It walks all sixteen byte-enable patterns over one word, and writes past the depth of the small store to catch a missing alias or a byte lane that leaks. It also measures the accept delay on every request, including a read and a write pending together. A wrong counter restart, or a write taken ahead of the read, would show up as a wrong wait or a wrong word. Finally, it sends bursts to every spare window and then re-reads the stores: a decode that falls through to store 0 would corrupt stored words or return them instead of all ones.

// File: rtl/tgt_resp_pkg.sv
package tgt_resp_pkg;

    localparam int HIT_W     = 7;
    localparam int NUM_STORE = 3;
    localparam int REM_W     = 12;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] sel;
    } region_t;

    function automatic region_t decode_hit(input logic [HIT_W-1:0] hit);
        region_t r;
        r.valid = 1'b1;
        r.sel   = 2'd0;
        if (hit[0])      r.sel = 2'd0;
        else if (hit[1]) r.sel = 2'd1;
        else if (hit[2]) r.sel = 2'd2;
        else begin
            r.valid = 1'b0;
            r.sel   = 2'd3;
        end
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tgt_accept_ctrl.sv
module tgt_accept_ctrl
    import tgt_resp_pkg::*;
#(
    parameter int ACC_WAIT   = 2,
    parameter int WORD_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REM_W-1:0] rem_bytes,
    output logic             accept,
    output logic             rd_go,
    output logic             wr_go
);
    localparam int CNT_W = (ACC_WAIT < 1) ? 1 : $clog2(ACC_WAIT + 1);

    xfer_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_rd_q;
    logic             pending;
    logic             dir_now;
    logic             in_xfer;
    logic             last_beat;

    always_comb begin
        pending   = rd_req | wr_req;
        accept    = (state_q == ST_IDLE) && pending && (cnt_q == CNT_W'(ACC_WAIT));
        dir_now   = accept ? rd_req : dir_rd_q;
        in_xfer   = accept || (state_q == ST_XFER);
        rd_go     = in_xfer && dir_now && rd_stb;
        wr_go     = in_xfer && !dir_now && wr_stb;
        last_beat = (rd_go || wr_go) && (rem_bytes <= REM_W'(WORD_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            dir_rd_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cnt_q    <= '0;
                        dir_rd_q <= rd_req;
                        state_q  <= last_beat ? ST_IDLE : ST_XFER;
                    end else if (pending) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= '0;
                    end
                end
                ST_XFER: begin
                    if (last_beat) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes from the engine only arrive inside an accepted transfer
    assert_stb_window_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> (state_q == ST_XFER || accept));

    // An open burst is only ever entered through an accept
    assert_xfer_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_XFER) |-> $past(accept));

endmodule

// File: rtl/tgt_addr_track.sv
module tgt_addr_track
    import tgt_resp_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int WB_LG  = 2,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [HIT_W-1:0]  bar_hit,
    output logic [IDX_W-1:0]  cur_idx,
    output region_t           cur_rgn
);
    logic [IDX_W-1:0] idx_q;
    region_t          rgn_q;
    logic [IDX_W-1:0] addr_idx;
    logic             unused_addr_bits;

    assign addr_idx         = laddr[WB_LG +: IDX_W];
    assign unused_addr_bits = ^{laddr[WB_LG-1:0], laddr[ADDR_W-1:WB_LG+IDX_W]};

    always_comb begin
        cur_idx = load ? addr_idx : idx_q;
        cur_rgn = load ? decode_hit(bar_hit) : rgn_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            rgn_q <= '{valid: 1'b0, sel: 2'd3};
        end else begin
            if (load || step) idx_q <= cur_idx + IDX_W'(step);
            if (load)         rgn_q <= decode_hit(bar_hit);
        end
    end

    // Mid-burst beats advance the word index by exactly one
    assert_step_one_word_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/tgt_region_store.sv
module tgt_region_store
    import tgt_resp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    parameter int R0_WORDS = 256,
    parameter int R1_WORDS = 64,
    parameter int R2_WORDS = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  region_t                rgn,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DATA_W/8-1:0]    be,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] rdword [4];

    assign rdword[3] = '1;

    for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
        localparam int D  = (g == 0) ? R0_WORDS : (g == 1) ? R1_WORDS : R2_WORDS;
        localparam int AW = $clog2(D);

        logic [DATA_W-1:0] mem [D];
        logic              hit_here;

        assign hit_here  = rgn.valid && (rgn.sel == 2'(g));
        assign rdword[g] = mem[idx[AW-1:0]];

        always_ff @(posedge clk) begin
            if (wr_en && hit_here) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (be[b]) mem[idx[AW-1:0]][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rgn.valid ? rdword[rgn.sel] : '1;
    end

    // Reads aimed at a window without storage come back as all ones
    assert_unused_ones_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rgn.valid) |=> (rd_data == '1));

    // Read data holds between read strobes
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/tgt_resp.sv
module tgt_resp
    import tgt_resp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 64,
    parameter int ACC_WAIT = 2,
    parameter int R0_WORDS = 256,
    parameter int R1_WORDS = 64,
    parameter int R2_WORDS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic                wr_req,
    output logic                accept,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [6:0]          bar_hit,
    input  logic [ADDR_W-1:0]   laddr,
    input  logic [DATA_W/8-1:0] byte_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [11:0]         rem_bytes,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int BE_W  = DATA_W / 8;
    localparam int WB_LG = $clog2(BE_W);
    localparam int IDX_W = $clog2(max3(R0_WORDS, R1_WORDS, R2_WORDS));

    logic             rd_go;
    logic             wr_go;
    logic [IDX_W-1:0] cur_idx;
    region_t          cur_rgn;

    tgt_accept_ctrl #(
        .ACC_WAIT   (ACC_WAIT),
        .WORD_BYTES (BE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .rem_bytes (rem_bytes),
        .accept    (accept),
        .rd_go     (rd_go),
        .wr_go     (wr_go)
    );

    tgt_addr_track #(
        .ADDR_W (ADDR_W),
        .WB_LG  (WB_LG),
        .IDX_W  (IDX_W)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    (rd_go || wr_go),
        .laddr   (laddr),
        .bar_hit (bar_hit),
        .cur_idx (cur_idx),
        .cur_rgn (cur_rgn)
    );

    tgt_region_store #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .R0_WORDS (R0_WORDS),
        .R1_WORDS (R1_WORDS),
        .R2_WORDS (R2_WORDS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .rd_en   (rd_go),
        .rgn     (cur_rgn),
        .idx     (cur_idx),
        .be      (byte_en),
        .wdata   (wr_data),
        .rd_data (rd_data)
    );

    // The window select is one-hot whenever a request is pending
    assert_hit_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req || wr_req) |-> $onehot0(bar_hit));

endmodule

// File: tb/tgt_resp_bench.sv
`timescale 1ns/1ps
module tgt_resp_bench;
    localparam int ACC_WAIT = 2;
    localparam int DEP0 = 16, DEP1 = 8, DEP2 = 16;

    logic        clk = 0;
    logic        rst = 1;
    logic        rd_req = 0, wr_req = 0, rd_stb = 0, wr_stb = 0;
    logic        accept;
    logic [6:0]  bar_hit = '0;
    logic [63:0] laddr = '0;
    logic [3:0]  byte_en = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rem_bytes = '0;
    logic [31:0] rd_data;

    int checks = 0, fails = 0;
    logic [31:0] gm [3][16];

    always #4 clk = ~clk;

    tgt_resp #(.DATA_W(32), .ADDR_W(64), .ACC_WAIT(ACC_WAIT),
               .R0_WORDS(DEP0), .R1_WORDS(DEP1), .R2_WORDS(DEP2)) u_tgt_resp (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .accept(accept),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .bar_hit(bar_hit), .laddr(laddr),
        .byte_en(byte_en), .wr_data(wr_data), .rem_bytes(rem_bytes), .rd_data(rd_data));

    function automatic int depth_of(input int h);
        return (h == 0) ? DEP0 : (h == 1) ? DEP1 : DEP2;
    endfunction

    function automatic logic [31:0] pat(input int seed, input int k);
        logic [7:0] s, kk;
        s  = 8'(seed);
        kk = 8'(k);
        return {s, kk, ~s, kk ^ 8'h5A};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input int h, input int w);
        if (h < 3) return gm[h][w % depth_of(h)];
        return '1;
    endfunction

    // One burst; laddr is left untouched after the accept so the block must track it
    task automatic xfer(input bit is_rd, input int h, input int start_w, input int n,
                        input logic [3:0] be, input int seed);
        int waits;
        logic [31:0] exp_q;
        bit have_rd;
        @(negedge clk);
        bar_hit   = 7'(1 << h);
        laddr     = 64'(start_w * 4 + (seed % 4));
        rem_bytes = 12'(n * 4);
        if (is_rd) rd_req = 1; else wr_req = 1;
        waits = 0;
        #1;
        while (!accept && waits < 40) begin
            @(negedge clk);
            waits++;
            #1;
        end
        check(waits == ACC_WAIT, "R2 accept delay", 32'(waits), 32'(ACC_WAIT));
        have_rd = 0;
        exp_q   = '0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                @(negedge clk);
                rd_req = 0;
                wr_req = 0;
                if (have_rd) check(rd_data == exp_q, "R4/R5/R7/R9/R11 read beat", rd_data, exp_q);
            end
            rem_bytes = 12'((n - k) * 4);
            byte_en   = be;
            if (is_rd) begin
                rd_stb  = 1;
                exp_q   = expect_rd(h, start_w + k);
                have_rd = 1;
            end else begin
                wr_stb  = 1;
                wr_data = pat(seed, k);
                if (h < 3) begin
                    for (int b = 0; b < 4; b++)
                        if (be[b]) gm[h][(start_w + k) % depth_of(h)][8*b +: 8] = wr_data[8*b +: 8];
                end
            end
        end
        @(negedge clk);
        rd_req = 0; wr_req = 0; rd_stb = 0; wr_stb = 0;
        if (have_rd) begin
            check(rd_data == exp_q, "R5/R10 read last beat", rd_data, exp_q);
            @(negedge clk);
            check(rd_data == exp_q, "R5 read data holds", rd_data, exp_q);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int h = 0; h < 3; h++)
            for (int i = 0; i < 16; i++) gm[h][i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(accept == 1'b0, "R1 accept low after reset", 32'(accept), 0);
        check(rd_data == 32'h0, "R1 rd_data zero after reset", rd_data, 0);

        // R9 R7 R4: fill each store in one burst, read back in one burst
        for (int h = 0; h < 3; h++) begin
            xfer(0, h, 0, depth_of(h), 4'hF, 16 + h);
            xfer(1, h, 0, depth_of(h), 4'h0, 1 + h);
        end

        // R7: burst starting mid-store with a nonzero byte offset
        xfer(0, 2, 5, 6, 4'hF, 41);
        xfer(1, 2, 3, 10, 4'hF, 3);

        // R11: store 1 aliases every 8 words
        xfer(0, 1, 11, 1, 4'hF, 77);
        xfer(1, 1, 3, 1, 4'hF, 0);
        xfer(1, 1, 6, 4, 4'hF, 0);

        // R6: every byte-enable pattern on one word
        for (int be = 0; be < 16; be++) begin
            xfer(0, 0, 5, 1, 4'(be), 100 + be);
            xfer(1, 0, 5, 1, 4'h0, 0);
        end

        // R10: spare and ROM windows accept, discard writes, read all ones
        for (int h = 3; h < 7; h++) begin
            xfer(0, h, 0, 4, 4'hF, 200 + h);
            xfer(1, h, 0, 4, 4'hF, 0);
        end
        xfer(1, 0, 0, 4, 4'hF, 0);
        xfer(1, 1, 0, 4, 4'hF, 0);
        xfer(1, 2, 0, 4, 4'hF, 0);

        // R8: no accept without a new request after a burst
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            check(accept == 1'b0, "R8 no accept while idle", 32'(accept), 0);
        end

        // R3: read and write pending together; read first
        begin
            int waits;
            logic [31:0] exp_q;
            logic [31:0] wv;
            @(negedge clk);
            bar_hit = 7'b0000001; laddr = 64'(2 * 4); rem_bytes = 12'd4;
            rd_req = 1; wr_req = 1;
            waits = 0;
            #1;
            while (!accept && waits < 40) begin @(negedge clk); waits++; #1; end
            check(waits == ACC_WAIT, "R3 first accept delay", 32'(waits), 32'(ACC_WAIT));
            rd_stb = 1;
            exp_q  = gm[0][2];
            @(negedge clk);
            rd_req = 0; rd_stb = 0;
            check(rd_data == exp_q, "R3 read served first", rd_data, exp_q);
            laddr = 64'(9 * 4);
            waits = 0;
            #1;
            while (!accept && waits < 40) begin @(negedge clk); waits++; #1; end
            check(waits == ACC_WAIT, "R3 write accept delay", 32'(waits), 32'(ACC_WAIT));
            wv = 32'hC0DE_5A17;
            wr_stb = 1; wr_data = wv; byte_en = 4'hF;
            gm[0][9] = wv;
            @(negedge clk);
            wr_req = 0; wr_stb = 0;
            xfer(1, 0, 9, 1, 4'hF, 0);
            xfer(1, 0, 2, 1, 4'hF, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule